// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a parallel NOR flash and interprets the stream of bus writes. Each write arrives as a one-cycle strobe with its address and data, already registered. The decoder recognises the multi-write unlock-keyed command sequences and emits one-cycle start strobes for word program, block erase and chip erase. With each program strobe it emits the latched target address and data. For block erase, a selection window collects one or more blocks into a bitmap, and the window restarts every time another block is added.

A width-mode input selects which unlock addresses apply: the byte-wide or the word-wide set. A bypass mode drops the two unlock writes from program and erase commands. Once entered, it stays active until its own two-write exit sequence is seen. The memory array, the analog timing and the status reporting lie outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the decoder returns to read mode. After that edge all strobes are 0, `erase_blocks` is all zeros, `bypass_on` is 0, and `prog_addr`/`prog_data` are 0.
- R2: A command starts with two unlock writes. The first is code 0xAA at address 0x555 in word mode (`x8_mode`=0) or 0xAAA in byte mode (`x8_mode`=1). The second is code 0x55 at 0x2AA in word mode or 0x555 in byte mode. Only `wr_addr[11:0]` is compared, and command codes are read from `wr_data[7:0]`.
- R3: Program: two unlock writes, then 0xA0 at the first unlock address, then a fourth write to any address. `prog_start` is high for exactly the cycle after the fourth write's edge. In that cycle `prog_addr`/`prog_data` hold that write's address and data, and both keep these values until the next program.
- R4: Chip erase: two unlock writes, 0x80 at the first unlock address, two unlock writes, then 0x10 at the first unlock address. `chip_start` pulses for one cycle after the sixth write.
- R5: Block erase: the same first five writes, then 0x30 at any address. This write replaces the bitmap with a single bit set at index `wr_addr[ADDR_W-1:BLK_SHIFT]`.
- R6: While blocks are being collected, each further 0x30 write ORs its block bit into `erase_blocks` and restarts the window. `erase_start` pulses for one cycle, TIMEOUT cycles after the edge of the last accepted block write, provided no write came in between. Any other write during the window cancels it with no strobe and clears `erase_blocks`.
- R7: Once `erase_start` has pulsed, no more blocks are accepted. A later 0x30 write produces no strobe and leaves `erase_blocks` unchanged.
- R8: A write that does not continue a valid sequence returns the decoder to read mode and is itself discarded. A later complete sequence is decoded normally.
- R9: Two unlock writes followed by 0x20 at the first unlock address set `bypass_on`.
- R10: In bypass mode, 0xA0 followed by a target write starts a program. 0x80 followed by 0x30 or 0x10 at any address starts a block erase (with the window of R6) or a chip erase.
- R11: In bypass mode, the read/reset code 0xF0 and any other write that is not a bypass command leave `bypass_on` set. Only 0x90 followed by 0x00 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x8_mode | input | 1 | 1 selects byte-mode unlock addresses, 0 word mode |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command code in bits 7:0 |
| prog_start | output | 1 | One-cycle program start strobe |
| prog_addr | output | ADDR_W | Latched program target address |
| prog_data | output | DATA_W | Latched program data |
| erase_start | output | 1 | One-cycle block erase start strobe |
| chip_start | output | 1 | One-cycle chip erase start strobe |
| erase_blocks | output | 2**(ADDR_W-BLK_SHIFT) | Bitmap of blocks selected for erase |
| bypass_on | output | 1 | Unlock-bypass mode active |

## Verification
The sequences are driven both in word mode and in byte mode. Byte mode is also driven with the word-mode addresses, which shows that the address set really follows the mode input, and the unlock address is also given with its high bits set, which shows that only the low twelve bits are compared. Block erase is tried with a single block and with several blocks spaced by idle gaps, which separates a window that restarts from one that only counts from the first block; a cancelled window and a late 0x30 write after the strobe show where collection stops. Corrupted unlock data and bypass-mode traffic (0xF0, a stray unlock, a wrong exit code, then the real exit) show which writes end the mode and which leave it.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   localparam int MATCH_W = 12;

   localparam logic [7:0] CODE_KEY1   = 8'hAA;
   localparam logic [7:0] CODE_KEY2   = 8'h55;
   localparam logic [7:0] CODE_PROG   = 8'hA0;
   localparam logic [7:0] CODE_ERSET  = 8'h80;
   localparam logic [7:0] CODE_BLOCK  = 8'h30;
   localparam logic [7:0] CODE_CHIP   = 8'h10;
   localparam logic [7:0] CODE_BYPIN  = 8'h20;
   localparam logic [7:0] CODE_BYPX1  = 8'h90;
   localparam logic [7:0] CODE_BYPX2  = 8'h00;

   localparam logic [MATCH_W-1:0] W16_FIRST  = 12'h555;
   localparam logic [MATCH_W-1:0] W16_SECOND = 12'h2AA;
   localparam logic [MATCH_W-1:0] B8_FIRST   = 12'hAAA;
   localparam logic [MATCH_W-1:0] B8_SECOND  = 12'h555;

   typedef enum logic [3:0] {
      ST_READ,
      ST_KEY1,
      ST_KEY2,
      ST_PGM,
      ST_ESET,
      ST_EKEY1,
      ST_EKEY2,
      ST_ECMD,
      ST_GATHER,
      ST_BYPX
   } fcd_state_e;
endpackage

// File: rtl/fcd_unlock_match.sv
module fcd_unlock_match
   import fcd_pkg::*;
(
   input  logic               x8_mode,
   input  logic [MATCH_W-1:0] addr_lo,
   output logic               at_first,
   output logic               at_second
);
   logic [MATCH_W-1:0] first_a, second_a;

   always_comb begin
      first_a   = x8_mode ? B8_FIRST  : W16_FIRST;
      second_a  = x8_mode ? B8_SECOND : W16_SECOND;
      at_first  = (addr_lo == first_a);
      at_second = (addr_lo == second_a);
   end
endmodule

// File: rtl/fcd_erase_window.sv
module fcd_erase_window #(
   parameter int BLK_W   = 4,
   parameter int TIMEOUT = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  first_blk,
   input  logic                  add_blk,
   input  logic                  drop,
   input  logic                  run,
   input  logic [BLK_W-1:0]      idx,
   output logic                  last,
   output logic [(1<<BLK_W)-1:0] bitmap
);
   localparam int NBLK = 1 << BLK_W;

   logic [NBLK-1:0] sel_bit;
   assign sel_bit = NBLK'(1) << idx;

   always_ff @(posedge clk) begin
      if (!rst_n)         bitmap <= '0;
      else if (first_blk) bitmap <= sel_bit;
      else if (add_blk)   bitmap <= bitmap | sel_bit;
      else if (drop)      bitmap <= '0;
   end

   generate
      if (TIMEOUT == 1) begin : g_no_count
         assign last = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(TIMEOUT + 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)                      cnt <= '0;
            else if (first_blk || add_blk)   cnt <= CNT_W'(TIMEOUT);
            else if (drop)                   cnt <= '0;
            else if (run && cnt != '0)       cnt <= cnt - 1'b1;
         end

         assign last = (cnt == CNT_W'(1));

         AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CNT_W'(TIMEOUT)); // R6
         AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (first_blk || add_blk) |=> (cnt == CNT_W'(TIMEOUT))); // R6
      end
   endgenerate

   AST_BITMAP_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      add_blk |=> ((bitmap & $past(bitmap)) == $past(bitmap))); // R6
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int BLK_SHIFT = 12,
   parameter int TIMEOUT   = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                x8_mode,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [DATA_W-1:0]                   wr_data,
   output logic                                prog_start,
   output logic [ADDR_W-1:0]                   prog_addr,
   output logic [DATA_W-1:0]                   prog_data,
   output logic                                erase_start,
   output logic                                chip_start,
   output logic [(1<<(ADDR_W-BLK_SHIFT))-1:0]  erase_blocks,
   output logic                                bypass_on
);
   localparam int BLK_W = ADDR_W - BLK_SHIFT;

   generate
      if (ADDR_W < MATCH_W) begin : g_bad_addr
         $error("ADDR_W must cover the unlock address bits");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold a command code");
      end
      if (BLK_SHIFT < 1 || BLK_W < 1 || BLK_W > 10) begin : g_bad_blk
         $error("BLK_SHIFT leaves an unusable block count");
      end
      if (TIMEOUT < 1) begin : g_bad_tmo
         $error("TIMEOUT must be at least one cycle");
      end
   endgenerate

   fcd_state_e state;
   logic       at_first, at_second, win_last;
   logic       blk_first, blk_add, blk_drop, win_run;
   logic [7:0] code;

   assign code = wr_data[7:0];

   fcd_unlock_match u_match (
      .x8_mode   (x8_mode),
      .addr_lo   (wr_addr[MATCH_W-1:0]),
      .at_first  (at_first),
      .at_second (at_second)
   );

   always_comb begin
      blk_first = (state == ST_ECMD)   &&  wr_en && (code == CODE_BLOCK);
      blk_add   = (state == ST_GATHER) &&  wr_en && (code == CODE_BLOCK);
      blk_drop  = (state == ST_GATHER) &&  wr_en && (code != CODE_BLOCK);
      win_run   = (state == ST_GATHER) && !wr_en;
   end

   fcd_erase_window #(.BLK_W(BLK_W), .TIMEOUT(TIMEOUT)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .first_blk (blk_first),
      .add_blk   (blk_add),
      .drop      (blk_drop),
      .run       (win_run),
      .idx       (wr_addr[ADDR_W-1:BLK_SHIFT]),
      .last      (win_last),
      .bitmap    (erase_blocks)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_READ;
         bypass_on   <= 1'b0;
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         chip_start  <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
      end else begin
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         chip_start  <= 1'b0;
         unique case (state)
            ST_READ: if (wr_en) begin
               if (bypass_on) begin
                  if (code == CODE_PROG)       state <= ST_PGM;
                  else if (code == CODE_ERSET) state <= ST_ECMD;
                  else if (code == CODE_BYPX1) state <= ST_BYPX;
               end else if (at_first && code == CODE_KEY1) begin
                  state <= ST_KEY1;
               end
            end
            ST_KEY1: if (wr_en)
               state <= (at_second && code == CODE_KEY2) ? ST_KEY2 : ST_READ;
            ST_KEY2: if (wr_en) begin
               state <= ST_READ;
               if (at_first) begin
                  if (code == CODE_PROG)       state <= ST_PGM;
                  else if (code == CODE_ERSET) state <= ST_ESET;
                  else if (code == CODE_BYPIN) bypass_on <= 1'b1;
               end
            end
            ST_PGM: if (wr_en) begin
               prog_start <= 1'b1;
               prog_addr  <= wr_addr;
               prog_data  <= wr_data;
               state      <= ST_READ;
            end
            ST_ESET: if (wr_en)
               state <= (at_first && code == CODE_KEY1) ? ST_EKEY1 : ST_READ;
            ST_EKEY1: if (wr_en)
               state <= (at_second && code == CODE_KEY2) ? ST_ECMD : ST_READ;
            ST_ECMD: if (wr_en) begin
               state <= ST_READ;
               if (code == CODE_BLOCK) state <= ST_GATHER;
               else if (code == CODE_CHIP && (bypass_on || at_first)) chip_start <= 1'b1;
            end
            ST_GATHER: begin
               if (wr_en) begin
                  if (code != CODE_BLOCK) state <= ST_READ;
               end else if (win_last) begin
                  erase_start <= 1'b1;
                  state       <= ST_READ;
               end
            end
            ST_BYPX: if (wr_en) begin
               if (code == CODE_BYPX2) bypass_on <= 1'b0;
               state <= ST_READ;
            end
            default: state <= ST_READ;
         endcase
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_start, erase_start, chip_start})); // R3
   AST_PROG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start && $past(rst_n)) |-> ($past(wr_en) && prog_addr == $past(wr_addr))); // R3
   AST_CHIP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_start && $past(rst_n)) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h10)); // R4
   AST_ERASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_start && $past(rst_n)) |-> !$past(wr_en)); // R6
   AST_ERASE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (erase_blocks != '0)); // R5
   AST_BYP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bypass_on) && $past(rst_n)) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h00)); // R11
   AST_BYP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bypass_on) && $past(rst_n)) |-> ($past(wr_en) && $past(wr_data[7:0]) == 8'h20)); // R9
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
   localparam int AW  = 16;
   localparam int DW  = 16;
   localparam int BS  = 12;
   localparam int TMO = 6;
   localparam int NB  = 1 << (AW - BS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          x8_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          prog_start, erase_start, chip_start, bypass_on;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_data;
   logic [NB-1:0] erase_blocks;

   always #2.5 clk = ~clk;

   flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .BLK_SHIFT(BS), .TIMEOUT(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .x8_mode(x8_mode), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_data(prog_data), .erase_start(erase_start),
      .chip_start(chip_start), .erase_blocks(erase_blocks), .bypass_on(bypass_on)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   // reference model state
   bit            m_byp = 0;
   bit            m_gather = 0;
   int            m_tmo = 0;
   bit [7:0]      q_code[$];
   bit [11:0]     q_addr[$];
   bit            e_prog = 0, e_ers = 0, e_chip = 0;
   bit [AW-1:0]   e_paddr = '0;
   bit [DW-1:0]   e_pdata = '0;
   bit [NB-1:0]   e_bmp = '0;

   task automatic compare();
      n_cmp++;
      if ({prog_start, erase_start, chip_start, bypass_on} !== {e_prog, e_ers, e_chip, m_byp} ||
          prog_addr !== e_paddr || prog_data !== e_pdata || erase_blocks !== e_bmp) begin
         n_bad++;
         $display("FAIL %s t=%0t actual p=%b e=%b c=%b b=%b pa=%h pd=%h map=%h expected p=%b e=%b c=%b b=%b pa=%h pd=%h map=%h",
                  cur_req, $time, prog_start, erase_start, chip_start, bypass_on, prog_addr,
                  prog_data, erase_blocks, e_prog, e_ers, e_chip, m_byp, e_paddr, e_pdata, e_bmp);
      end
   endtask

   task automatic model_step(bit rst, bit en, bit [AW-1:0] a, bit [DW-1:0] d);
      bit [11:0] k1, k2, lo;
      bit [7:0]  c;
      bit        keep;
      int        n;
      k1 = x8_mode ? 12'hAAA : 12'h555;
      k2 = x8_mode ? 12'h555 : 12'h2AA;
      lo = a[11:0];
      c  = d[7:0];
      e_prog = 0; e_ers = 0; e_chip = 0;
      if (!rst) begin
         m_byp = 0; m_gather = 0; m_tmo = 0; e_paddr = '0; e_pdata = '0; e_bmp = '0;
         q_code.delete(); q_addr.delete();
         return;
      end
      if (m_gather) begin
         if (en) begin
            if (c == 8'h30) begin
               e_bmp[a[AW-1:BS]] = 1'b1; m_tmo = TMO;
            end else begin
               m_gather = 0; e_bmp = '0;
            end
         end else if (m_tmo == 1) begin
            e_ers = 1; m_gather = 0;
         end else begin
            m_tmo--;
         end
         return;
      end
      if (!en) return;
      q_code.push_back(c); q_addr.push_back(lo);
      n = q_code.size();
      keep = 0;
      if (!m_byp) begin
         case (n)
            1: keep = (lo == k1 && c == 8'hAA);
            2: keep = (lo == k2 && c == 8'h55);
            3: if (lo == k1) begin
                  if (c == 8'hA0 || c == 8'h80) keep = 1;
                  else if (c == 8'h20) m_byp = 1;
               end
            4: if (q_code[2] == 8'hA0) begin
                  e_prog = 1; e_paddr = a; e_pdata = d;
               end else keep = (lo == k1 && c == 8'hAA);
            5: keep = (lo == k2 && c == 8'h55);
            6: if (c == 8'h30) begin
                  m_gather = 1; m_tmo = TMO; e_bmp = '0; e_bmp[a[AW-1:BS]] = 1'b1;
               end else if (c == 8'h10 && lo == k1) e_chip = 1;
            default: keep = 0;
         endcase
      end else begin
         case (n)
            1: keep = (c == 8'hA0 || c == 8'h80 || c == 8'h90);
            2: if (q_code[0] == 8'hA0) begin
                  e_prog = 1; e_paddr = a; e_pdata = d;
               end else if (q_code[0] == 8'h80) begin
                  if (c == 8'h30) begin
                     m_gather = 1; m_tmo = TMO; e_bmp = '0; e_bmp[a[AW-1:BS]] = 1'b1;
                  end else if (c == 8'h10) e_chip = 1;
               end else if (c == 8'h00) m_byp = 0;
            default: keep = 0;
         endcase
      end
      if (!keep) begin
         q_code.delete(); q_addr.delete();
      end
   endtask

   task automatic step(bit rst, bit en, bit [AW-1:0] a, bit [DW-1:0] d);
      @(negedge clk);
      compare();
      rst_n = rst; wr_en = en; wr_addr = a; wr_data = d;
      model_step(rst, en, a, d);
   endtask

   task automatic wr(bit [AW-1:0] a, bit [DW-1:0] d);
      step(1, 1, a, d);
      step(1, 0, '0, '0);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1, 0, '0, '0);
   endtask

   task automatic erase_head(bit [AW-1:0] k1, bit [AW-1:0] k2);
      wr(k1, 16'h00AA); wr(k2, 16'h0055); wr(k1, 16'h0080);
      wr(k1, 16'h00AA); wr(k2, 16'h0055);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: all requirements, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      cur_req = "R1";
      for (int i = 0; i < 4; i++) step(0, 0, '0, '0);
      idle(3);

      cur_req = "R3";
      wr(16'h0555, 16'h00AA); idle(2); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
      step(1, 1, 16'h1234, 16'hBEEF); idle(4);

      cur_req = "R2";
      wr(16'hF555, 16'h00AA); wr(16'h82AA, 16'h0055); wr(16'h4555, 16'h00A0);
      wr(16'h0042, 16'h1357); idle(2);
      x8_mode = 1'b1;
      wr(16'h0AAA, 16'h00AA); wr(16'h0555, 16'h0055); wr(16'h0AAA, 16'h00A0);
      wr(16'h0777, 16'h00C3); idle(2);
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
      wr(16'h0888, 16'h0011); idle(2);
      x8_mode = 1'b0;

      cur_req = "R4";
      erase_head(16'h0555, 16'h02AA); wr(16'h0555, 16'h0010); idle(3);
      erase_head(16'h0555, 16'h02AA); wr(16'h0123, 16'h0010); idle(3);

      cur_req = "R5";
      erase_head(16'h0555, 16'h02AA); step(1, 1, 16'h3456, 16'h0030); idle(TMO + 3);

      cur_req = "R6";
      erase_head(16'h0555, 16'h02AA); step(1, 1, 16'h1000, 16'h0030);
      idle(3); step(1, 1, 16'h7ABC, 16'h0030);
      idle(TMO - 1); step(1, 1, 16'hF123, 16'h0030); idle(TMO + 3);
      erase_head(16'h0555, 16'h02AA); step(1, 1, 16'h2000, 16'h0030);
      idle(2); step(1, 1, 16'h0000, 16'h00F0); idle(TMO + 3);

      cur_req = "R7";
      erase_head(16'h0555, 16'h02AA); step(1, 1, 16'h5000, 16'h0030); idle(TMO + 1);
      step(1, 1, 16'h6000, 16'h0030); idle(TMO + 3);

      cur_req = "R8";
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0056); wr(16'h02AA, 16'h0055);
      wr(16'h0555, 16'h00A0); wr(16'h0999, 16'h0999); idle(2);
      wr(16'h0555, 16'h00AA); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
      wr(16'h0555, 16'h00A0); wr(16'h0ABC, 16'h4242); idle(2);

      cur_req = "R9";
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0020); idle(2);

      cur_req = "R10";
      wr(16'h0000, 16'h00A0); wr(16'h0321, 16'hA5A5); idle(2);
      wr(16'h0000, 16'h0080); step(1, 1, 16'h9000, 16'h0030); idle(2);
      step(1, 1, 16'hB000, 16'h0030); idle(TMO + 2);
      wr(16'h0000, 16'h0080); wr(16'h0777, 16'h0010); idle(2);

      cur_req = "R11";
      wr(16'h0000, 16'h00F0); idle(2);
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h00A0);
      wr(16'h0444, 16'h0044); idle(2);
      wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0001); idle(2);
      wr(16'h0000, 16'h0090); wr(16'h0000, 16'h0000); idle(2);
      wr(16'h0000, 16'h00A0); wr(16'h0666, 16'h0066); idle(3);

      cur_req = "R1";
      wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0020);
      step(0, 0, '0, '0); idle(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule